// File: doc/BRIEF.md
# Video Sync Polarity Conditioner and Line Pulse Regenerator

This block sits in a pixel-clocked video capture path and conditions the horizontal and vertical sync signals before they reach downstream timing logic. For each sync input it decides which level is the active one. That decision comes either from an automatic detector, which compares high time against low time over one period, or from a user polarity bit. For vertical sync it also chooses the source. The source is either the external sync pin or the output of a composite-sync separator, picked automatically from pin activity or by a user select bit.

The horizontal sync output is not passed through. A fresh pulse is started by a phase-adjusted line reference pulse, and it lasts a programmed number of pixel clocks. The vertical sync output is normalised to active high. It can optionally be held so that its edges move only on a line reference, which keeps it aligned with horizontal sync. Both outputs are driven at their own programmable output polarity. All configuration arrives on plain register inputs.

Top module: `sync_cond`

## Requirements
- R1: After reset, with output polarity inputs at 1 and no line reference, `hs_o` and `vs_o` are 0, `hs_act_high_o` and `vs_act_high_o` are 1, and `vs_src_sep_o` is 1 (separator chosen).
- R2: A line reference sampled with width W (1 to 255) makes `hs_o` show its active level for exactly W cycles, starting on the next cycle. The active level is the value of `hs_out_pol_i`: 1 means active high and 0 means active low.
- R3: A line reference sampled with width 0 produces no active cycle on `hs_o`.
- R4: A line reference that arrives while a pulse is running restarts the count. The pulse then lasts W cycles after the restarting reference.
- R5: With `hs_pol_ovr_i`=0, `hs_act_high_o` is updated only at a rising edge of `hs_i`. It is set to 0 (active low) when the high time of the period just ended exceeds its low time, and to 1 otherwise.
- R6: With `hs_pol_ovr_i`=1, `hs_act_high_o` equals `hs_pol_usr_i` (0 active low, 1 active high).
- R7: With `vs_src_ovr_i`=0, `vs_src_sep_o` goes to 0 (pin) while `vs_i` has toggled within the last SRC_TIMEOUT cycles. It goes to 1 (separator) after SRC_TIMEOUT cycles with no edge on `vs_i`.
- R8: With `vs_src_ovr_i`=1, `vs_src_sep_o` takes the value of `vs_src_usr_i` one cycle later (0 pin, 1 separator), and the selected signal feeds the vertical path.
- R9: With the filter off, `vs_o` shows, one cycle later, the selected vertical sync normalised by its active polarity and then driven at `vs_out_pol_i` (1 active high, 0 active low). With `vs_pol_ovr_i`=1, `vs_pol_usr_i` gives the input polarity.
- R10: With `vs_filt_en_i`=1, the active state of `vs_o` changes only on the cycle after a sampled line reference. A vertical sync change is held until that line reference.
- R11: With `vs_pol_ovr_i`=0, `vs_act_high_o` is 0 when the selected vertical sync's high time exceeds its low time over a period, and 1 otherwise. It is updated at each rising edge of that signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_i | input | 1 | Horizontal sync input, synchronous to clk_i |
| vs_i | input | 1 | Vertical sync pin input, synchronous to clk_i |
| sep_vs_i | input | 1 | Vertical sync from composite-sync separator |
| line_ref_i | input | 1 | Phase-adjusted line reference pulse |
| hs_pol_ovr_i | input | 1 | 1: use hs_pol_usr_i, 0: auto detect |
| hs_pol_usr_i | input | 1 | User horizontal input polarity (1 active high) |
| hs_out_pol_i | input | 1 | Horizontal output polarity (1 active high) |
| hs_width_i | input | HS_W | Horizontal pulse width in pixel clocks |
| vs_src_ovr_i | input | 1 | 1: use vs_src_usr_i, 0: auto source |
| vs_src_usr_i | input | 1 | User vertical source (0 pin, 1 separator) |
| vs_pol_ovr_i | input | 1 | 1: use vs_pol_usr_i, 0: auto detect |
| vs_pol_usr_i | input | 1 | User vertical input polarity (1 active high) |
| vs_out_pol_i | input | 1 | Vertical output polarity (1 active high) |
| vs_filt_en_i | input | 1 | Align vertical sync edges to line reference |
| hs_o | output | 1 | Regenerated horizontal sync |
| vs_o | output | 1 | Conditioned vertical sync |
| hs_act_high_o | output | 1 | Effective horizontal input polarity |
| vs_act_high_o | output | 1 | Effective vertical input polarity |
| vs_src_sep_o | output | 1 | Effective vertical source (1 separator) |

## Verification
The assertions assume that every sync input and the line reference are already synchronous to the pixel clock, with no metastable samples. They also assume that the line reference is one cycle wide. The horizontal detection property further assumes that the polarity override does not change in the cycle it checks. The bench drives all inputs on the falling edge, so each value is stable for a whole cycle. It changes configuration only while the line reference is low, and it emits line references as single-cycle pulses.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;
  typedef enum logic {SRC_PIN = 1'b0, SRC_SEP = 1'b1} vs_src_e;
endpackage

// File: rtl/sync_pol_det.sv
module sync_pol_det #(
  parameter int CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic act_high_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             prev_q, seen_q, det_q;
  logic [CNT_W-1:0] hi_cnt_q, lo_cnt_q;
  logic             rise;

  assign rise = sync_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      seen_q   <= 1'b0;
      det_q    <= 1'b1;
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
    end else begin
      prev_q <= sync_i;
      if (rise) begin
        // first rise only opens a measurement window
        if (seen_q) det_q <= !(hi_cnt_q > lo_cnt_q);
        seen_q   <= 1'b1;
        hi_cnt_q <= ONE;
        lo_cnt_q <= '0;
      end else if (sync_i) begin
        if (!(&hi_cnt_q)) hi_cnt_q <= hi_cnt_q + ONE;
      end else begin
        if (!(&lo_cnt_q)) lo_cnt_q <= lo_cnt_q + ONE;
      end
    end
  end

  assign act_high_o = det_q;
endmodule

// File: rtl/hs_regen.sv
module hs_regen #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         line_ref_i,
  input  logic [W-1:0] width_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (line_ref_i)    cnt_q <= width_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/vs_src_sel.sv
module vs_src_sel
  import sync_cond_pkg::*;
#(
  parameter int TIMEOUT = 4096
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pin_i,
  input  logic    ovr_i,
  input  logic    usr_i,
  output vs_src_e src_o
);
  localparam int TO_W = $clog2(TIMEOUT + 1);
  localparam logic [TO_W-1:0] LAST = TO_W'(TIMEOUT - 1);

  logic            pin_q, active_q;
  logic [TO_W-1:0] idle_q;
  vs_src_e         src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q    <= 1'b0;
      active_q <= 1'b0;
      idle_q   <= '0;
    end else begin
      pin_q <= pin_i;
      if (pin_i != pin_q) begin
        idle_q   <= '0;
        active_q <= 1'b1;
      end else if (idle_q == LAST) begin
        active_q <= 1'b0;
      end else begin
        idle_q <= idle_q + TO_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    src_q <= SRC_SEP;
    else if (ovr_i) src_q <= vs_src_e'(usr_i);
    else            src_q <= active_q ? SRC_PIN : SRC_SEP;
  end

  assign src_o = src_q;
endmodule

// File: rtl/vs_align.sv
module vs_align (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_norm_i,
  input  logic filt_en_i,
  input  logic line_ref_i,
  output logic vs_o
);
  logic vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       vs_q <= 1'b0;
    else if (!filt_en_i || line_ref_i) vs_q <= vs_norm_i;
  end

  assign vs_o = vs_q;
endmodule

// File: rtl/sync_cond.sv
module sync_cond
  import sync_cond_pkg::*;
#(
  parameter int HS_W        = 8,
  parameter int HS_CNT_W    = 16,
  parameter int VS_CNT_W    = 24,
  parameter int SRC_TIMEOUT = 4096
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hs_i,
  input  logic            vs_i,
  input  logic            sep_vs_i,
  input  logic            line_ref_i,
  input  logic            hs_pol_ovr_i,
  input  logic            hs_pol_usr_i,
  input  logic            hs_out_pol_i,
  input  logic [HS_W-1:0] hs_width_i,
  input  logic            vs_src_ovr_i,
  input  logic            vs_src_usr_i,
  input  logic            vs_pol_ovr_i,
  input  logic            vs_pol_usr_i,
  input  logic            vs_out_pol_i,
  input  logic            vs_filt_en_i,
  output logic            hs_o,
  output logic            vs_o,
  output logic            hs_act_high_o,
  output logic            vs_act_high_o,
  output logic            vs_src_sep_o
);
  logic    hs_pulse, hs_det_high, vs_det_high;
  logic    vs_sel_raw, vs_norm, vs_aligned;
  vs_src_e vs_src;

  sync_pol_det #(.CNT_W(HS_CNT_W)) u_hs_det (
    .clk_i, .rst_ni, .sync_i(hs_i), .act_high_o(hs_det_high)
  );

  hs_regen #(.W(HS_W)) u_hs_regen (
    .clk_i, .rst_ni, .line_ref_i, .width_i(hs_width_i), .pulse_o(hs_pulse)
  );

  vs_src_sel #(.TIMEOUT(SRC_TIMEOUT)) u_vs_src (
    .clk_i, .rst_ni, .pin_i(vs_i), .ovr_i(vs_src_ovr_i),
    .usr_i(vs_src_usr_i), .src_o(vs_src)
  );

  assign vs_sel_raw = (vs_src == SRC_SEP) ? sep_vs_i : vs_i;

  sync_pol_det #(.CNT_W(VS_CNT_W)) u_vs_det (
    .clk_i, .rst_ni, .sync_i(vs_sel_raw), .act_high_o(vs_det_high)
  );

  assign hs_act_high_o = hs_pol_ovr_i ? hs_pol_usr_i : hs_det_high;
  assign vs_act_high_o = vs_pol_ovr_i ? vs_pol_usr_i : vs_det_high;
  assign vs_norm       = vs_act_high_o ? vs_sel_raw : ~vs_sel_raw;

  vs_align u_vs_align (
    .clk_i, .rst_ni, .vs_norm_i(vs_norm), .filt_en_i(vs_filt_en_i),
    .line_ref_i, .vs_o(vs_aligned)
  );

  assign hs_o         = hs_out_pol_i ? hs_pulse : ~hs_pulse;
  assign vs_o         = vs_out_pol_i ? vs_aligned : ~vs_aligned;
  assign vs_src_sep_o = (vs_src == SRC_SEP);
endmodule

// File: rtl/sync_cond_chk.sv
module sync_cond_chk #(
  parameter int HS_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            hs_i,
  input logic            line_ref_i,
  input logic [HS_W-1:0] hs_width_i,
  input logic            hs_pulse,
  input logic            hs_pol_ovr_i,
  input logic            hs_act_high_o,
  input logic            vs_src_ovr_i,
  input logic            vs_src_usr_i,
  input logic            vs_src_sep_o,
  input logic            vs_filt_en_i,
  input logic            vs_out_pol_i,
  input logic            vs_o
);
  assert_pulse_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_ref_i && hs_width_i != '0) |=> hs_pulse);

  assert_zero_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_ref_i && hs_width_i == '0) |=> !hs_pulse);

  assert_det_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_pol_ovr_i && $past(!hs_pol_ovr_i) && !$stable(hs_act_high_o))
      |-> ($past(hs_i) && !$past(hs_i, 2)));

  assert_src_override_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_src_ovr_i |=> (vs_src_sep_o == $past(vs_src_usr_i)));

  assert_filter_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_filt_en_i && !line_ref_i)
      |=> ((vs_o ^ vs_out_pol_i) == $past(vs_o ^ vs_out_pol_i)));
endmodule

bind sync_cond sync_cond_chk #(.HS_W(HS_W)) u_sync_cond_chk (
  .clk_i, .rst_ni, .hs_i, .line_ref_i, .hs_width_i, .hs_pulse,
  .hs_pol_ovr_i, .hs_act_high_o, .vs_src_ovr_i, .vs_src_usr_i,
  .vs_src_sep_o, .vs_filt_en_i, .vs_out_pol_i, .vs_o
);

// File: tb/sync_cond_bench.sv
`timescale 1ns/1ps
module sync_cond_bench;
  localparam int TMO = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hs, vs, sep_vs, line_ref;
  logic hs_pol_ovr, hs_pol_usr, hs_out_pol;
  logic [7:0] hs_width;
  logic vs_src_ovr, vs_src_usr, vs_pol_ovr, vs_pol_usr, vs_out_pol, vs_filt_en;
  logic hs_o, vs_o, hs_act_high, vs_act_high, vs_src_sep;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_cond #(.SRC_TIMEOUT(TMO)) u_sync_cond (
    .clk_i(clk), .rst_ni(rst_n), .hs_i(hs), .vs_i(vs), .sep_vs_i(sep_vs),
    .line_ref_i(line_ref), .hs_pol_ovr_i(hs_pol_ovr), .hs_pol_usr_i(hs_pol_usr),
    .hs_out_pol_i(hs_out_pol), .hs_width_i(hs_width), .vs_src_ovr_i(vs_src_ovr),
    .vs_src_usr_i(vs_src_usr), .vs_pol_ovr_i(vs_pol_ovr), .vs_pol_usr_i(vs_pol_usr),
    .vs_out_pol_i(vs_out_pol), .vs_filt_en_i(vs_filt_en), .hs_o(hs_o), .vs_o(vs_o),
    .hs_act_high_o(hs_act_high), .vs_act_high_o(vs_act_high), .vs_src_sep_o(vs_src_sep)
  );

  // {out_pol, width}; expected active cycles = width
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'd1}, {1'b0, 8'd5}, {1'b1, 8'd255},
    {1'b1, 8'd0}, {1'b0, 8'd0}, {1'b1, 8'd17}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // fire one reference, count active hs cycles; optional restart at step rs
  task automatic hs_count(input int rs, output int cnt);
    line_ref = 1'b1;
    @(negedge clk);
    line_ref = 1'b0;
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      if (hs_o == hs_out_pol) cnt++;
      line_ref = (k == rs);
      @(negedge clk);
    end
    line_ref = 1'b0;
  endtask

  task automatic hs_wave(input int hi, input int lo, input int n);
    for (int p = 0; p < n; p++) begin
      hs = 1'b1; cyc(hi);
      hs = 1'b0; cyc(lo);
    end
  endtask

  task automatic vs_wave(input int hi, input int lo, input int n);
    for (int p = 0; p < n; p++) begin
      vs = 1'b1; cyc(hi);
      vs = 1'b0; cyc(lo);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    hs = 0; vs = 0; sep_vs = 0; line_ref = 0;
    hs_pol_ovr = 0; hs_pol_usr = 1; hs_out_pol = 1; hs_width = 8'd0;
    vs_src_ovr = 0; vs_src_usr = 0; vs_pol_ovr = 0; vs_pol_usr = 1;
    vs_out_pol = 1; vs_filt_en = 0;
    cyc(3);
    // R1 reset state
    chk("R1 hs_o", hs_o, 0);
    chk("R1 vs_o", vs_o, 0);
    chk("R1 hs_act_high", hs_act_high, 1);
    chk("R1 vs_act_high", vs_act_high, 1);
    chk("R1 vs_src_sep", vs_src_sep, 1);
    rst_n = 1'b1;
    cyc(2);

    // R2/R3 table walk
    for (int i = 0; i < 6; i++) begin
      hs_out_pol = VEC[i][8];
      hs_width   = VEC[i][7:0];
      cyc(2);
      hs_count(-1, cnt);
      chk(VEC[i][7:0] == 0 ? "R3 zero width" : "R2 width", cnt, int'(VEC[i][7:0]));
    end

    // R4 restart mid-pulse: 3 cycles then full width again
    hs_out_pol = 1; hs_width = 8'd10;
    cyc(2);
    hs_count(2, cnt);
    chk("R4 restart", cnt, 13);

    // R5 auto hs polarity
    hs_wave(4, 16, 3);
    chk("R5 short high", hs_act_high, 1);
    hs_wave(16, 4, 3);
    chk("R5 long high", hs_act_high, 0);

    // R6 user hs polarity
    hs_pol_ovr = 1; hs_pol_usr = 0; cyc(1);
    chk("R6 user low", hs_act_high, 0);
    hs_pol_usr = 1; cyc(1);
    chk("R6 user high", hs_act_high, 1);

    // R7 auto source
    vs_wave(2, 2, 3);
    cyc(3);
    chk("R7 pin active", vs_src_sep, 0);
    cyc(TMO + 10);
    chk("R7 pin timeout", vs_src_sep, 1);

    // R8 user source, separator feeds path
    vs_src_ovr = 1; vs_src_usr = 1;
    vs_pol_ovr = 1; vs_pol_usr = 1; vs_out_pol = 1;
    sep_vs = 1; vs = 0;
    cyc(3);
    chk("R8 sep selected", vs_src_sep, 1);
    chk("R8 sep drives vs_o", vs_o, 1);
    sep_vs = 0;
    vs_src_usr = 0; vs = 1;
    cyc(3);
    chk("R8 pin selected", vs_src_sep, 0);
    chk("R8 pin drives vs_o", vs_o, 1);

    // R9 polarity chain, filter off
    vs_pol_usr = 0; vs = 0; cyc(2);
    chk("R9 active-low in", vs_o, 1);
    vs = 1; cyc(1);
    chk("R9 one-cycle latency", vs_o, 0);
    vs = 0; vs_out_pol = 0; cyc(1);
    chk("R9 active-low out", vs_o, 0);

    // R10 filter hold until line reference
    vs_pol_usr = 1; vs_out_pol = 1; vs = 0; hs_width = 8'd4;
    cyc(2);
    vs_filt_en = 1;
    cyc(1);
    vs = 1;
    cyc(5);
    chk("R10 held", vs_o, 0);
    line_ref = 1; cyc(1); line_ref = 0;
    chk("R10 released", vs_o, 1);
    vs = 0; cyc(4);
    chk("R10 held fall", vs_o, 1);
    line_ref = 1; cyc(1); line_ref = 0;
    chk("R10 released fall", vs_o, 0);
    vs_filt_en = 0;

    // R11 auto vs polarity on pin
    vs_pol_ovr = 0;
    vs_wave(3, 37, 3);
    chk("R11 short high", vs_act_high, 1);
    vs_wave(37, 3, 3);
    chk("R11 long high", vs_act_high, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule